// File: doc/BRIEF.md
# Raster Reconstruction Periodic Averager

This block turns a stream of demodulated amplitude samples into a small greyscale image. Every valid sample stands for one slice of elapsed time. The block uses programmable pixel, line and frame periods to find the pixel position each slice belongs to. Samples that land on the same visible position in successive frames are added into a per-pixel sum. Content that repeats with the frame rate therefore builds up, while uncorrelated noise averages out.

A run starts with a `start` pulse. The pulse clears the sums and resets the position to the top-left corner. A programmable number of leading samples can be discarded first, which shifts the start time and so aligns the picture. The frame period is set in lines with a 16-bit fraction, so a frame may hold a non-integer number of lines. The time left over at each frame wrap carries into the next frame as a horizontal offset. After 2^k frames, every sum is shifted right by k, then offset, scaled and clamped to 8 bits, and the pixels stream out in raster order. A `done` level follows the last pixel.

Top module: `raster_avg`

## Requirements
- R1: While reset is held and right after it is released, `pixValid` and `done` are 0.
- R2: Position follows elapsed time. Sample k after the alignment point has time T = k·`cfgStep`, in pixels with 16 fractional bits. With P = `cfgLineLen`·`cfgFrameLines`, the frame is n = floor(T/P). With u = T − n·P, the line is y = floor(u/(`cfgLineLen`·2^16)) and x = floor((u − y·`cfgLineLen`·2^16)/2^16).
- R3: The first `cfgStartSkip` valid samples after an accepted start are discarded and advance no position.
- R4: Samples with x ≥ VIS_W or y ≥ VIS_H are not added to any sum.
- R5: An accepted start clears every per-pixel sum, so data from an earlier run never reaches a later result.
- R6: Each pixel sum adds all samples of frames 0 to 2^`cfgAvgLog`−1 that map to it, saturating at 2^16−1. The averaged value is the sum shifted right by `cfgAvgLog`.
- R7: The output byte is computed from the averaged value a and the offset: max(a − `cfgOffset`, 0), times `cfgGain` (unsigned, 4 fractional bits), shifted right by 4, clamped to 255.
- R8: The edge that takes the sample completing the last frame starts the readout. `pixValid` rises on the next edge and stays high for VIS_W·VIS_H consecutive cycles, carrying pixel index y·VIS_W+x in increasing order.
- R9: `done` rises in the cycle after the last pixel and holds until the next accepted start. Samples arriving during readout or while `done` is high change no result.
- R10: `start` is accepted only when no run is active, that is before the first run or while `done` is high. A pulse during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new averaging run |
| sampleValid | input | 1 | Sample present this cycle |
| sampleData | input | 8 | Demodulated amplitude |
| cfgStep | input | 20 | Pixels advanced per sample, 16 fractional bits |
| cfgLineLen | input | 8 | Total pixels per line, integer |
| cfgFrameLines | input | 24 | Total lines per frame, 16 fractional bits |
| cfgStartSkip | input | 16 | Samples discarded before the first pixel |
| cfgAvgLog | input | 3 | log2 of the number of frames averaged |
| cfgOffset | input | 16 | Subtracted from the averaged value |
| cfgGain | input | 8 | Contrast gain, 4 fractional bits |
| pixValid | output | 1 | Output pixel present |
| pixData | output | 8 | Grey value |
| done | output | 1 | Readout complete |

## Verification
Accumulation has no visible latency. The readout is tied to the sample that completes the final frame: the first pixel is due one edge after that sample is taken, and the remaining pixels follow on consecutive cycles. `done` follows one cycle after the last pixel. The driver computes every expected pixel from the time formula before it sends any sample, and queues the values in raster order. The monitor samples on the falling edge and pops one entry for each cycle with `pixValid` high, so any shift or gap in the burst shows up as a mismatch or as a missing or extra pixel. After the burst, the bench checks that the queue is empty and that `done` is high and stays high.

// File: rtl/rra_pkg.sv
package rra_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP,
    ST_ACCUM,
    ST_READOUT,
    ST_FINISH
  } rra_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic accumEn;
    logic readEn;
  } rra_ctl_t;

endpackage

// File: rtl/rra_pos.sv
module rra_pos #(
  parameter int FRAC_W     = 16,
  parameter int LINE_W     = 8,
  parameter int LINES_W    = 8,
  parameter int STEP_INT_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        restart,
  input  logic                        advance,
  input  logic [STEP_INT_W+FRAC_W-1:0] cfgStep,
  input  logic [LINE_W-1:0]           cfgLineLen,
  input  logic [LINES_W+FRAC_W-1:0]   cfgFrameLines,
  output logic [LINE_W-1:0]           xIdx,
  output logic [LINES_W-1:0]          yIdx,
  output logic                        frameWrap
);
  localparam int HPOS_W = LINE_W + FRAC_W;
  localparam int FPIX_W = LINE_W + LINES_W + FRAC_W;

  logic [FPIX_W-1:0] framePix;
  logic [FPIX_W-1:0] tFrame;
  logic [FPIX_W:0]   tNext;
  logic [FPIX_W:0]   tLeft;
  logic [HPOS_W-1:0] hPos;
  logic [HPOS_W:0]   hNext;
  logic [HPOS_W:0]   lineLim;
  logic              lineWrap;

  // frame period in pixels: line length times fractional line count
  assign framePix = FPIX_W'(cfgLineLen) * FPIX_W'(cfgFrameLines);
  assign tNext    = {1'b0, tFrame} + (FPIX_W+1)'(cfgStep);
  assign tLeft    = tNext - {1'b0, framePix};
  assign frameWrap = (tNext >= {1'b0, framePix});

  assign lineLim  = {1'b0, cfgLineLen, {FRAC_W{1'b0}}};
  assign hNext    = {1'b0, hPos} + (HPOS_W+1)'(cfgStep);
  assign lineWrap = (hNext >= lineLim);

  assign xIdx = hPos[FRAC_W +: LINE_W];

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      tFrame <= '0;
      hPos   <= '0;
      yIdx   <= '0;
    end else if (advance) begin
      if (frameWrap) begin
        // leftover time starts the next frame as a horizontal phase
        tFrame <= tLeft[FPIX_W-1:0];
        hPos   <= tLeft[HPOS_W-1:0];
        yIdx   <= '0;
      end else begin
        tFrame <= tNext[FPIX_W-1:0];
        if (lineWrap) begin
          hPos <= HPOS_W'(hNext - lineLim);
          yIdx <= yIdx + 1'b1;
        end else begin
          hPos <= hNext[HPOS_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/rra_ctrl.sv
module rra_ctrl
  import rra_pkg::*;
#(
  parameter int NPIX    = 128,
  parameter int START_W = 16,
  parameter int MLOG_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        sampleValid,
  input  logic                        frameWrap,
  input  logic [START_W-1:0]          cfgStartSkip,
  input  logic [MLOG_W-1:0]           cfgAvgLog,
  output rra_ctl_t                    ctl,
  output logic [$clog2(NPIX)-1:0]     rdAddr,
  output logic                        done
);
  localparam int ADDR_W = $clog2(NPIX);
  localparam int FCNT_W = 1 << MLOG_W;

  rra_state_t        state;
  logic [START_W-1:0] skipCnt;
  logic [FCNT_W-1:0]  frameCnt;
  logic               startOk;
  logic               lastFrame;

  assign startOk   = start && (state == ST_IDLE || state == ST_FINISH);
  assign lastFrame = (frameCnt == ((FCNT_W'(1) << cfgAvgLog) - FCNT_W'(1)));

  always_comb begin
    ctl.clearAll = startOk;
    ctl.accumEn  = (state == ST_ACCUM) && sampleValid;
    ctl.readEn   = (state == ST_READOUT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      skipCnt  <= '0;
      frameCnt <= '0;
      rdAddr   <= '0;
      done     <= 1'b0;
    end else begin
      done <= (state == ST_FINISH) && !startOk;
      if (startOk) begin
        skipCnt  <= '0;
        frameCnt <= '0;
        rdAddr   <= '0;
        state    <= (cfgStartSkip == '0) ? ST_ACCUM : ST_SKIP;
      end else begin
        case (state)
          ST_SKIP: if (sampleValid) begin
            skipCnt <= skipCnt + 1'b1;
            if (skipCnt == cfgStartSkip - START_W'(1)) state <= ST_ACCUM;
          end
          ST_ACCUM: if (sampleValid && frameWrap) begin
            if (lastFrame) state <= ST_READOUT;
            else frameCnt <= frameCnt + 1'b1;
          end
          ST_READOUT: begin
            rdAddr <= rdAddr + 1'b1;
            if (rdAddr == ADDR_W'(NPIX - 1)) state <= ST_FINISH;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/rra_datapath.sv
module rra_datapath
  import rra_pkg::*;
#(
  parameter int VIS_W     = 16,
  parameter int VIS_H     = 8,
  parameter int SAMPLE_W  = 8,
  parameter int SUM_W     = 16,
  parameter int LINE_W    = 8,
  parameter int LINES_W   = 8,
  parameter int MLOG_W    = 3,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  rra_ctl_t                       ctl,
  input  logic [SAMPLE_W-1:0]            sampleData,
  input  logic [LINE_W-1:0]              xIdx,
  input  logic [LINES_W-1:0]             yIdx,
  input  logic [$clog2(VIS_W*VIS_H)-1:0] rdAddr,
  input  logic [MLOG_W-1:0]              cfgAvgLog,
  input  logic [SUM_W-1:0]               cfgOffset,
  input  logic [GAIN_W-1:0]              cfgGain,
  output logic                           pixValid,
  output logic [7:0]                     pixData
);
  localparam int NPIX   = VIS_W * VIS_H;
  localparam int ADDR_W = $clog2(NPIX);
  localparam int PROD_W = SUM_W + GAIN_W;

  logic [SUM_W-1:0]  sumMem [NPIX];
  logic              inWin;
  logic [ADDR_W-1:0] wrAddr;
  logic [SUM_W:0]    addTmp;
  logic [SUM_W-1:0]  rdSum, avg, diff;
  logic [PROD_W-1:0] prod, scaled;
  logic [7:0]        pixNext;

  assign inWin  = (32'(xIdx) < VIS_W) && (32'(yIdx) < VIS_H);
  assign wrAddr = ADDR_W'(32'(yIdx) * VIS_W + 32'(xIdx));
  assign addTmp = {1'b0, sumMem[wrAddr]} + (SUM_W+1)'(sampleData);

  always_ff @(posedge clk) begin
    if (rst || ctl.clearAll) begin
      for (int i = 0; i < NPIX; i++) sumMem[i] <= '0;
    end else if (ctl.accumEn && inWin) begin
      sumMem[wrAddr] <= addTmp[SUM_W] ? {SUM_W{1'b1}} : addTmp[SUM_W-1:0];
    end
  end

  // average, offset, gain, clamp
  always_comb begin
    rdSum  = sumMem[rdAddr];
    avg    = rdSum >> cfgAvgLog;
    diff   = (avg < cfgOffset) ? '0 : avg - cfgOffset;
    prod   = PROD_W'(diff) * PROD_W'(cfgGain);
    scaled = prod >> GAIN_FRAC;
    pixNext = (|scaled[PROD_W-1:8]) ? 8'hFF : scaled[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pixValid <= 1'b0;
      pixData  <= '0;
    end else begin
      pixValid <= ctl.readEn;
      pixData  <= pixNext;
    end
  end

endmodule

// File: rtl/raster_avg.sv
module raster_avg
  import rra_pkg::*;
#(
  parameter int VIS_W      = 16,
  parameter int VIS_H      = 8,
  parameter int SAMPLE_W   = 8,
  parameter int FRAC_W     = 16,
  parameter int LINE_W     = 8,
  parameter int LINES_W    = 8,
  parameter int STEP_INT_W = 4,
  parameter int START_W    = 16,
  parameter int MLOG_W     = 3,
  parameter int SUM_W      = 16,
  parameter int GAIN_W     = 8,
  parameter int GAIN_FRAC  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         sampleValid,
  input  logic [SAMPLE_W-1:0]          sampleData,
  input  logic [STEP_INT_W+FRAC_W-1:0] cfgStep,
  input  logic [LINE_W-1:0]            cfgLineLen,
  input  logic [LINES_W+FRAC_W-1:0]    cfgFrameLines,
  input  logic [START_W-1:0]           cfgStartSkip,
  input  logic [MLOG_W-1:0]            cfgAvgLog,
  input  logic [SUM_W-1:0]             cfgOffset,
  input  logic [GAIN_W-1:0]            cfgGain,
  output logic                         pixValid,
  output logic [7:0]                   pixData,
  output logic                         done
);
  localparam int NPIX   = VIS_W * VIS_H;
  localparam int ADDR_W = $clog2(NPIX);

  rra_ctl_t           ctl;
  logic [ADDR_W-1:0]  rdAddr;
  logic [LINE_W-1:0]  xIdx;
  logic [LINES_W-1:0] yIdx;
  logic               frameWrap;

  rra_ctrl #(.NPIX(NPIX), .START_W(START_W), .MLOG_W(MLOG_W)) uCtrl (
    .clk(clk), .rst(rst), .start(start), .sampleValid(sampleValid),
    .frameWrap(frameWrap), .cfgStartSkip(cfgStartSkip), .cfgAvgLog(cfgAvgLog),
    .ctl(ctl), .rdAddr(rdAddr), .done(done)
  );

  rra_pos #(.FRAC_W(FRAC_W), .LINE_W(LINE_W), .LINES_W(LINES_W),
            .STEP_INT_W(STEP_INT_W)) uPos (
    .clk(clk), .rst(rst), .restart(ctl.clearAll), .advance(ctl.accumEn),
    .cfgStep(cfgStep), .cfgLineLen(cfgLineLen), .cfgFrameLines(cfgFrameLines),
    .xIdx(xIdx), .yIdx(yIdx), .frameWrap(frameWrap)
  );

  rra_datapath #(.VIS_W(VIS_W), .VIS_H(VIS_H), .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W),
                 .LINE_W(LINE_W), .LINES_W(LINES_W), .MLOG_W(MLOG_W),
                 .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) uData (
    .clk(clk), .rst(rst), .ctl(ctl), .sampleData(sampleData),
    .xIdx(xIdx), .yIdx(yIdx), .rdAddr(rdAddr), .cfgAvgLog(cfgAvgLog),
    .cfgOffset(cfgOffset), .cfgGain(cfgGain),
    .pixValid(pixValid), .pixData(pixData)
  );

endmodule

// File: rtl/raster_avg_checker.sv
module raster_avg_checker #(
  parameter int NPIX = 128
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic pixValid,
  input logic done
);
  int unsigned runLen;

  always_ff @(posedge clk) begin
    if (rst) runLen <= 0;
    else if (pixValid) runLen <= runLen + 1;
    else runLen <= 0;
  end

  // R9: no pixel is produced once the run has finished
  p_done_no_pix_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !pixValid);

  // R9: done holds until a new start arrives
  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R8: every readout burst is exactly one full window
  p_burst_len_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(pixValid) |-> (runLen == NPIX));

  // R9: done is up in the first cycle after the burst
  p_done_after_burst_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(pixValid) |-> done);

  // R8: a burst never begins while done is high
  p_burst_start_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(pixValid) |-> !$past(done));

endmodule

bind raster_avg raster_avg_checker #(.NPIX(VIS_W * VIS_H)) uChk (
  .clk(clk), .rst(rst), .start(start), .pixValid(pixValid), .done(done)
);

// File: tb/raster_avg_test.sv
`timescale 1ns/1ps
module raster_avg_test;
  localparam int VIS_W = 16;
  localparam int VIS_H = 8;
  localparam int NPIX  = VIS_W * VIS_H;

  logic        clk = 0;
  logic        rst = 1;
  logic        start = 0;
  logic        sampleValid = 0;
  logic [7:0]  sampleData = 0;
  logic [19:0] cfgStep = 0;
  logic [7:0]  cfgLineLen = 0;
  logic [23:0] cfgFrameLines = 0;
  logic [15:0] cfgStartSkip = 0;
  logic [2:0]  cfgAvgLog = 0;
  logic [15:0] cfgOffset = 0;
  logic [7:0]  cfgGain = 0;
  logic        pixValid;
  logic [7:0]  pixData;
  logic        done;

  int tests = 0;
  int fails = 0;
  int pixIdx = 0;
  int expQ[$];
  longint sums[NPIX];

  always #2.5 clk = ~clk;

  raster_avg uut (
    .clk(clk), .rst(rst), .start(start), .sampleValid(sampleValid),
    .sampleData(sampleData), .cfgStep(cfgStep), .cfgLineLen(cfgLineLen),
    .cfgFrameLines(cfgFrameLines), .cfgStartSkip(cfgStartSkip),
    .cfgAvgLog(cfgAvgLog), .cfgOffset(cfgOffset), .cfgGain(cfgGain),
    .pixValid(pixValid), .pixData(pixData), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops one expected pixel per valid output cycle (R8 order)
  always @(negedge clk) begin
    if (!rst && pixValid) begin
      if (expQ.size() == 0) begin
        check(0, "R8 extra pixel", pixIdx, -1);
      end else begin
        int e;
        e = expQ.pop_front();
        check(pixData == e, $sformatf("R2/R4/R6/R7 pixel %0d", pixIdx), pixData, e);
      end
      pixIdx++;
    end
  end

  // R2 time model: frame, line, column of sample k
  function automatic void locate(input longint k, input longint step, input longint lineLen,
                                 input longint frameLines, output longint n,
                                 output longint x, output longint y);
    longint t, p, u, lf;
    t  = k * step;
    p  = lineLen * frameLines;
    n  = t / p;
    u  = t - n * p;
    lf = lineLen << 16;
    y  = u / lf;
    x  = (u - y * lf) >> 16;
  endfunction

  function automatic int fmtPix(input longint s, input int mlog, input longint off, input longint gain);
    longint a, d, p;
    a = s >> mlog;
    d = (a < off) ? 0 : a - off;
    p = (d * gain) >> 4;
    return (p > 255) ? 255 : int'(p);
  endfunction

  function automatic int sampleVal(input int mode, input longint x, input longint y,
                                   input longint n, input longint k);
    if (mode == 2) return 255;
    return int'((x * 13 + y * 29 + n * 3 + (k % 5)) & 8'hFF) >> mode;
  endfunction

  task automatic runCase(input string name, input int mode, input longint step,
                         input longint lineLen, input longint frameLines, input int skip,
                         input int mlog, input longint off, input longint gain,
                         input int gapEvery, input int midStartAt);
    longint n, x, y, k;
    int cnt;
    cfgStep = 20'(step); cfgLineLen = 8'(lineLen); cfgFrameLines = 24'(frameLines);
    cfgStartSkip = 16'(skip); cfgAvgLog = 3'(mlog); cfgOffset = 16'(off); cfgGain = 8'(gain);
    for (int i = 0; i < NPIX; i++) sums[i] = 0;
    // expected result, computed before any stimulus
    k = 0;
    forever begin
      locate(k, step, lineLen, frameLines, n, x, y);
      if (n >= (64'd1 << mlog)) break;
      if (x < VIS_W && y < VIS_H) begin
        sums[y * VIS_W + x] += sampleVal(mode, x, y, n, k);
        if (sums[y * VIS_W + x] > 65535) sums[y * VIS_W + x] = 65535;
      end
      k++;
    end
    for (int i = 0; i < NPIX; i++) expQ.push_back(fmtPix(sums[i], mlog, off, gain));
    pixIdx = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    // R3: leading samples carry a bright value that must not appear
    for (int i = 0; i < skip; i++) begin
      sampleValid = 1; sampleData = 8'hFF; @(negedge clk);
    end
    k = 0; cnt = 0;
    forever begin
      locate(k, step, lineLen, frameLines, n, x, y);
      if (n >= (64'd1 << mlog)) break;
      if (gapEvery != 0 && (cnt % gapEvery) == gapEvery - 1) begin
        sampleValid = 0; @(negedge clk); cnt++;
        continue;
      end
      sampleValid = 1;
      sampleData  = 8'(sampleVal(mode, x, y, n, k));
      start = (k == midStartAt);  // R10: start during a run
      @(negedge clk);
      start = 0;
      k++; cnt++;
    end
    // R9: samples during readout are ignored
    for (int i = 0; i < NPIX + 4; i++) begin
      sampleValid = 1; sampleData = 8'hAA; @(negedge clk);
    end
    sampleValid = 0;
    cnt = 0;
    while (!done && cnt < 1000) begin @(negedge clk); cnt++; end
    check(done == 1, {"R9 done after readout ", name}, done, 1);
    check(expQ.size() == 0, {"R8 missing pixels ", name}, expQ.size(), 0);
    check(pixIdx == NPIX, {"R8 pixel count ", name}, pixIdx, NPIX);
    repeat (3) @(negedge clk);
    check(done == 1 && pixValid == 0, {"R9 done holds ", name}, done, 1);
    expQ.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pixValid == 0, "R1 pixValid in reset", pixValid, 0);
    check(done == 0, "R1 done in reset", done, 0);
    rst = 0;
    @(negedge clk);
    check(pixValid == 0 && done == 0, "R1 idle after reset", {pixValid, done}, 0);
    // R2 R4 R6: 10.5 lines per frame, lines wider and frames taller than window
    runCase("c1", 0, 64'h10000, 20, 64'hA8000, 0, 2, 0, 16'h10, 4, -1);
    // R3 R5 R7 R10: skip, clear after previous run, offset and gain, ignored start
    runCase("c2", 1, 64'h8000, 18, 64'h94000, 7, 1, 10, 16'h20, 3, 50);
    // R6 saturation: about 273 samples of 255 per pixel, single frame
    runCase("c3", 2, 64'h00F0, 16, 64'h80000, 0, 0, 65000, 16'h04, 0, -1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule